// File: doc/BRIEF.md
# Partial Word Transfer Selector

This block moves data between a 36-bit storage word and a 36-bit operand register under a 4-bit field code. On a read, it picks out a half, a third or a sixth of the storage word and places that field in the low-order bits of the result. It then either clears the bits above the field or copies the field's top bit into them. Two codes skip storage and take the operand from the instruction's address field instead.

On a store, the same code chooses which field of the storage word receives the low-order bits of the operand register. Every other bit of the storage word keeps its old value, so the caller writes the returned word back as a read-modify-write. A store that names an immediate code has no field to write. It raises a flag and returns the storage word untouched.

The selection logic is combinational. Every result is captured in a register one clock after the request strobe.

Top module: `partial_field_mover`

## Requirements
- R1: Code 0 selects the whole word. A read returns `mem_word_i` unchanged, and a store returns `reg_word_i` unchanged.
- R2: Codes 1 and 2 read bits 17:0 and 35:18 and clear bits 35:18 of the result. Codes 3 and 4 read the same two halves and fill bits 35:18 of the result with the field's top bit.
- R3: Codes 5, 6 and 7 read bits 11:0, 23:12 and 35:24 respectively. The field's top bit is copied into bits 35:12 of the result.
- R4: Codes 8 to 13 (octal 10 to 15) read the sixths from right to left: code 8 reads bits 5:0, and each code after it reads the 6 bits above the previous one, up to bits 35:30 for code 13. Bits 35:6 of the result are zero.
- R5: On a read, code 14 (octal 16) returns `imm_i` with zeros above it. Code 15 (octal 17) returns `imm_i` with bit IMM_W-1 copied into all higher bits. `mem_word_i` plays no part in either.
- R6: A store with codes 0 to 13 returns `mem_word_i` with the field that the code selects (the same bit ranges as R1 to R4) replaced by the low-order bits of `reg_word_i`. All other bits are unchanged.
- R7: A store with code 14 or 15 sets `illegal_o` to 1 and returns `wr_word_o` equal to `mem_word_i`. Every other strobe, read or store, clears `illegal_o`.
- R8: `valid_o` is 1 exactly in the cycle after a cycle with `strobe_i` high. `rd_data_o` changes only after a read strobe, and `wr_word_o` changes only after a store strobe. Both hold their values otherwise.
- R9: While `rst_n` is low, `valid_o`, `illegal_o`, `rd_data_o` and `wr_word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Request; the inputs are sampled in this cycle |
| write_i | input | 1 | 1 = store into the field, 0 = read from the field |
| code_i | input | 4 | Field code |
| mem_word_i | input | 36 | Current storage word |
| reg_word_i | input | 36 | Operand register value to be stored |
| imm_i | input | IMM_W | Address field of the instruction, used by immediate codes |
| valid_o | output | 1 | Results were updated this cycle |
| rd_data_o | output | 36 | Right-justified, extended read result |
| wr_word_o | output | 36 | Merged storage word for a store |
| illegal_o | output | 1 | The last request was a store with an immediate code |

## Verification
The assertions compare the registered outputs with the inputs of the previous cycle, using `$past`. They therefore assume that a strobe's inputs are steady at the clock edge that captures them, and that reset is held long enough for that edge to see strobe low. The bench drives every input on the falling edge and keeps `strobe_i` low throughout reset. It holds `strobe_i` high for exactly one cycle per request and sweeps every code, in both directions, over edge patterns and pseudo-random words.

// File: rtl/partial_field_mover.sv
module partial_field_mover #(
  parameter int IMM_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             write_i,
  input  logic [3:0]       code_i,
  input  logic [35:0]      mem_word_i,
  input  logic [35:0]      reg_word_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             valid_o,
  output logic [35:0]      rd_data_o,
  output logic [35:0]      wr_word_o,
  output logic             illegal_o
);
  localparam int WORD_W  = 36;
  localparam int HALF_W  = WORD_W / 2;
  localparam int THIRD_W = WORD_W / 3;
  localparam int SIXTH_W = WORD_W / 6;
  localparam int PAD_W   = WORD_W - IMM_W;

  logic [5:0]        lo;
  logic [5:0]        wid;
  logic              sgn;
  logic [WORD_W-1:0] low_mask, field_mask, raw, ext, imm_ext, rd_next, wr_next;
  logic              top_bit, is_imm;

  always_comb begin
    lo  = '0;
    wid = 6'(WORD_W);
    sgn = 1'b0;
    case (code_i)
      4'd0:  begin lo = '0;             wid = 6'(WORD_W);  end
      4'd1:  begin lo = '0;             wid = 6'(HALF_W);  end
      4'd2:  begin lo = 6'(HALF_W);     wid = 6'(HALF_W);  end
      4'd3:  begin lo = '0;             wid = 6'(HALF_W);  sgn = 1'b1; end
      4'd4:  begin lo = 6'(HALF_W);     wid = 6'(HALF_W);  sgn = 1'b1; end
      4'd5:  begin lo = '0;             wid = 6'(THIRD_W); sgn = 1'b1; end
      4'd6:  begin lo = 6'(THIRD_W);    wid = 6'(THIRD_W); sgn = 1'b1; end
      4'd7:  begin lo = 6'(2*THIRD_W);  wid = 6'(THIRD_W); sgn = 1'b1; end
      4'd8:  begin lo = '0;             wid = 6'(SIXTH_W); end
      4'd9:  begin lo = 6'(SIXTH_W);    wid = 6'(SIXTH_W); end
      4'd10: begin lo = 6'(2*SIXTH_W);  wid = 6'(SIXTH_W); end
      4'd11: begin lo = 6'(3*SIXTH_W);  wid = 6'(SIXTH_W); end
      4'd12: begin lo = 6'(4*SIXTH_W);  wid = 6'(SIXTH_W); end
      4'd13: begin lo = 6'(5*SIXTH_W);  wid = 6'(SIXTH_W); end
      default: begin lo = '0;           wid = 6'(WORD_W);  end
    endcase
  end

  assign low_mask   = (WORD_W'(1) << wid) - WORD_W'(1);
  assign field_mask = low_mask << lo;
  assign raw        = (mem_word_i >> lo) & low_mask;
  assign top_bit    = |(raw & (low_mask ^ (low_mask >> 1)));
  assign ext        = (sgn && top_bit) ? (raw | ~low_mask) : raw;
  assign is_imm     = (code_i[3:1] == 3'b111);
  assign imm_ext    = code_i[0] ? {{PAD_W{imm_i[IMM_W-1]}}, imm_i} : {{PAD_W{1'b0}}, imm_i};
  assign rd_next    = is_imm ? imm_ext : ext;
  assign wr_next    = is_imm ? mem_word_i
                             : ((mem_word_i & ~field_mask) | ((reg_word_i << lo) & field_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_data_o <= '0;
      wr_word_o <= '0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        illegal_o <= write_i && is_imm;
        if (write_i) wr_word_o <= wr_next;
        else         rd_data_o <= rd_next;
      end
    end
  end

  p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> valid_o);
  p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(rd_data_o) && $stable(wr_word_o) && $stable(illegal_o)));
  p_whole_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !write_i && code_i == 4'd0) |=> rd_data_o == $past(mem_word_i));
  p_half_unsigned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !write_i && (code_i == 4'd1 || code_i == 4'd2)) |=> rd_data_o[35:18] == 18'd0);
  p_sixth_unsigned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !write_i && code_i >= 4'd8 && code_i <= 4'd13) |=> rd_data_o[35:6] == 30'd0);
  p_third_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !write_i && code_i == 4'd7) |=> rd_data_o[35:11] == {25{$past(mem_word_i[35])}});
  p_imm_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !write_i && code_i == 4'd14) |=> rd_data_o == {{PAD_W{1'b0}}, $past(imm_i)});
  p_store_right_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && write_i && code_i == 4'd1) |=>
      (wr_word_o[35:18] == $past(mem_word_i[35:18]) && wr_word_o[17:0] == $past(reg_word_i[17:0])));
  p_illegal_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && write_i && code_i[3:1] == 3'b111) |=> (illegal_o && wr_word_o == $past(mem_word_i)));
  p_legal_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !(write_i && code_i[3:1] == 3'b111)) |=> !illegal_o);
endmodule

// File: tb/partial_field_mover_tb.sv
module partial_field_mover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IMM_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_i = 1'b0;
  logic write_i = 1'b0;
  logic [3:0] code_i = '0;
  logic [35:0] mem_word_i = '0;
  logic [35:0] reg_word_i = '0;
  logic [IMM_W-1:0] imm_i = '0;
  logic valid_o, illegal_o;
  logic [35:0] rd_data_o, wr_word_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  longint unsigned seed = 64'h0123_4567_89AB_CDEF;

  partial_field_mover #(.IMM_W(IMM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .write_i(write_i), .code_i(code_i),
    .mem_word_i(mem_word_i), .reg_word_i(reg_word_i), .imm_i(imm_i),
    .valid_o(valid_o), .rd_data_o(rd_data_o), .wr_word_o(wr_word_o), .illegal_o(illegal_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint unsigned next_word();
    seed = seed * 64'h5851F42D4C957F2D + 64'h14057B7EF767814F;
    return (seed >> 20) & 64'hF_FFFF_FFFF;
  endfunction

  // field position, width and signedness from the code, per R1-R4
  task automatic field_of(input int code, output int lo, output int w, output bit sg);
    sg = 0;
    if (code == 0) begin lo = 0; w = 36; end
    else if (code <= 4) begin lo = (code % 2 == 1) ? 0 : 18; w = 18; sg = (code >= 3); end
    else if (code <= 7) begin lo = (code - 5) * 12; w = 12; sg = 1; end
    else begin lo = (code - 8) * 6; w = 6; end
  endtask

  task automatic run(input bit wr, input int code, input longint unsigned m,
                     input longint unsigned r, input longint unsigned im);
    longint unsigned exp, pw, fsz, fld, prev_rd, prev_wr;
    int lo, w;
    bit sg;
    string tag;
    prev_rd = rd_data_o;
    prev_wr = wr_word_o;
    @(negedge clk);
    strobe_i = 1; write_i = wr; code_i = 4'(code);
    mem_word_i = 36'(m); reg_word_i = 36'(r); imm_i = IMM_W'(im);
    @(negedge clk);
    strobe_i = 0;
    check("R8 valid after strobe", valid_o, 1);
    if (code >= 14) begin
      if (wr) begin
        check("R7 illegal store flag", illegal_o, 1);
        check("R7 illegal store keeps word", wr_word_o, m);
        check("R8 read result held on store", rd_data_o, prev_rd);
      end else begin
        if (code == 15 && im >= (64'd1 << (IMM_W-1))) exp = (im + 64'hF_FFFF_FFFF - (64'd1 << IMM_W) + 1) & 64'hF_FFFF_FFFF;
        else exp = im;
        check("R5 immediate read", rd_data_o, exp);
        check("R7 read clears flag", illegal_o, 0);
        check("R8 store result held on read", wr_word_o, prev_wr);
      end
    end else begin
      field_of(code, lo, w, sg);
      pw  = 64'd1 << lo;
      fsz = 64'd1 << w;
      fld = (m / pw) % fsz;
      tag = (code == 0) ? "R1" : (code <= 4) ? "R2" : (code <= 7) ? "R3" : "R4";
      if (wr) begin
        exp = m - fld * pw + (r % fsz) * pw;
        check((code == 0) ? "R1 whole store" : "R6 field store", wr_word_o, exp);
        check("R7 legal store clears flag", illegal_o, 0);
        check("R8 read result held on store", rd_data_o, prev_rd);
      end else begin
        exp = fld;
        if (sg && fld >= fsz / 2) exp = (64'h10_0000_0000 - fsz) + fld;
        check({tag, " field read"}, rd_data_o, exp);
        check("R8 store result held on read", wr_word_o, prev_wr);
      end
    end
    prev_rd = rd_data_o;
    prev_wr = wr_word_o;
    @(negedge clk);
    check("R8 valid drops", valid_o, 0);
    check("R8 outputs hold", {rd_data_o, wr_word_o} == {36'(prev_rd), 36'(prev_wr)}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint unsigned pats [6];
    pats[0] = 64'h0_0000_0000; pats[1] = 64'hF_FFFF_FFFF;
    pats[2] = 64'h5_5555_5555; pats[3] = 64'hA_AAAA_AAAA;
    pats[4] = 64'h8_2082_0820; pats[5] = 64'h7_DF7D_F7DF;
    repeat (3) @(negedge clk);
    check("R9 reset valid", valid_o, 0);
    check("R9 reset illegal", illegal_o, 0);
    check("R9 reset read data", rd_data_o, 0);
    check("R9 reset store word", wr_word_o, 0);
    rst_n = 1;
    for (int code = 0; code < 16; code++) begin
      for (int p = 0; p < 6; p++) begin
        run(0, code, pats[p], pats[5-p], pats[p] & 64'h3_FFFF);
        run(1, code, pats[p], pats[5-p], pats[p] & 64'h3_FFFF);
      end
      for (int k = 0; k < 8; k++) begin
        run(0, code, next_word(), next_word(), next_word() & 64'h3_FFFF);
        run(1, code, next_word(), next_word(), next_word() & 64'h3_FFFF);
      end
    end
    // flag cleared by a following legal store after an illegal one
    run(1, 15, 64'h1_2345_6789, 64'hF_FFFF_FFFF, 64'h2_0000);
    run(1, 8, 64'h1_2345_6789, 64'h0_0000_002A, 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule